// File: doc/BRIEF.md
# Transmit Packet Assembler

This block turns a host-loaded byte queue and a handful of parallel configuration inputs into the serial bit stream of one outgoing radio packet. On air the packet carries, in this order: an 8-bit alternating preamble, a destination address of one to five bytes, an optional sender address of the same length, a payload of one to thirty-two bytes, and a 16-bit checksum. Every byte goes out most significant bit first, one bit per clock, with a valid strobe beside the data bit.

The destination address comes from one of two places, chosen by a configuration bit. It can be a stored address presented on a parallel input. It can also be a set of bytes that the host pushes into the queue ahead of the payload, most significant byte first. The sender address, when enabled, always comes from its own parallel input. All configuration is captured when a packet is accepted, so the host may change it while the packet is being sent. A one-cycle completion pulse follows the final checksum bit.

Top module: `pkt_tx_assembler`

## Requirements
- R1: One clock after a start pulse is accepted in the idle state, `tx_valid` rises and the first 8 bits are 1,0,1,0,1,0,1,0. `tx_valid` then stays high without a gap, one bit per clock, until the last checksum bit.
- R2: The address length L is `cfg_addr_len`, with 0 treated as 1 and any value above 5 treated as 5. The destination field is 8*L bits long.
- R3: With `cfg_dest_inline`=0, the destination field is byte L-1 down to byte 0 of `cfg_dest_addr`, where byte k is bits [8k+7:8k]. Queue contents are not used for this field.
- R4: With `cfg_dest_inline`=1, the destination field is the first L bytes taken from the queue, in the order they were written. `cfg_dest_addr` is not used.
- R5: With `cfg_src_en`=1, a sender field of 8*L bits follows the destination: byte L-1 down to byte 0 of `cfg_src_addr`. With `cfg_src_en`=0 the field is absent.
- R6: The payload field is P bytes taken from the queue in write order. P is `cfg_payload_len`, with 0 treated as 1 and any value above 32 treated as 32.
- R7: The last 16 bits are a CRC sent MSB first. It uses polynomial 0x1021 and start value 0xFFFF, with no final inversion. It is computed bit-serially, MSB first, over the destination, sender and payload bits only.
- R8: `done` is high for exactly one clock, in the cycle right after the last checksum bit, and `tx_valid` is low in that cycle.
- R9: While `busy` is high, a `start` pulse is ignored and configuration changes have no effect on the packet being sent. After `done`, no further bits are sent without a new start.
- R10: A synchronous active-low reset clears `tx_valid`, `done` and `busy` and empties the byte queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to send one packet; accepted only when idle |
| cfg_addr_len | input | 3 | Address length in bytes (clamped to 1..5) |
| cfg_dest_inline | input | 1 | 1: destination taken from queue bytes; 0: from `cfg_dest_addr` |
| cfg_src_en | input | 1 | Include the sender address field |
| cfg_payload_len | input | 6 | Payload length in bytes (clamped to 1..32) |
| cfg_dest_addr | input | 40 | Stored destination address, byte k at bits [8k+7:8k] |
| cfg_src_addr | input | 40 | Stored sender address, byte k at bits [8k+7:8k] |
| q_wr | input | 1 | Push one byte into the queue |
| q_wdata | input | 8 | Byte to push |
| tx_bit | output | 1 | Serial data bit |
| tx_valid | output | 1 | `tx_bit` carries a packet bit this cycle |
| done | output | 1 | One-cycle pulse after the final bit |
| busy | output | 1 | A packet is in progress (including the `done` cycle) |

## Verification
The table of packets covers a set of field layouts. The shortest packet has a one-byte address, no sender and one payload byte. The longest has five-byte addresses on both sides and thirty-two payload bytes. Inline and stored destinations are mixed with sender on and off, and two layouts use out-of-range lengths that must clamp. Each packet is checked field by field, which tells apart bytes taken from the wrong source, the wrong byte order, a sender field that is wrongly present or missing, and a checksum that covers the wrong span.

An inline layout sets `cfg_dest_addr` to a different value, so the two destination sources give different bits. A disturbed run shows that a mid-packet start pulse or configuration change is ignored. A reset with stale bytes in the queue shows that the queue is flushed.

// File: rtl/ptx_pkg.sv
// Package ptx_pkg
// Shared types and constants for the transmit packet assembler.
// Assumes bit-serial, MSB-first transmission of every field.
package ptx_pkg;

    // Packet field currently being serialised.
    typedef enum logic [2:0] {
        F_PRE = 3'd0,
        F_DST = 3'd1,
        F_SRC = 3'd2,
        F_PAY = 3'd3,
        F_CRC = 3'd4
    } field_e;

    // Bit-level transmitter state.
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_SEND = 2'd1,
        S_FIN  = 2'd2
    } tx_state_e;

    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;
    localparam logic [7:0]  PREAMBLE = 8'hAA;

    // One MSB-first CRC step for a single input bit.
    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[15] ^ b;
        crc_step = {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    endfunction

endpackage

// File: rtl/ptx_byte_fifo.sv
// Module ptx_byte_fifo
// Byte queue loaded by the host and drained by the field sequencer.
// Head byte is visible combinationally; a pop consumes it on the clock edge.
// Assumes the host loads every byte a packet needs before starting it.
// Writes while full and pops while empty are dropped.
module ptx_byte_fifo #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  logic       pop,
    output logic [7:0] head,
    output logic       empty
);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [AW:0]   count;
    logic          full;
    logic          do_wr;
    logic          do_rd;

    assign full  = (count == FULL_CNT);
    assign empty = (count == '0);
    assign do_wr = wr && !full;
    assign do_rd = pop && !empty;
    assign head  = mem[rd_ptr];

    // Storage array: written on accepted pushes, never reset.
    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + AW'(1);
            if (do_rd) rd_ptr <= rd_ptr + AW'(1);
            case ({do_wr, do_rd})
                2'b10:   count <= count + (AW+1)'(1);
                2'b01:   count <= count - (AW+1)'(1);
                default: count <= count;
            endcase
        end
    end

    // R6: the sequencer never pulls a byte the host has not supplied.
    p_no_pop_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    // R10: occupancy stays within the array.
    p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R10: one cycle after reset the queue reads empty.
    p_reset_empties_r10: assert property (@(posedge clk)
        !rst_n |=> empty);

endmodule

// File: rtl/ptx_crc16.sv
// Module ptx_crc16
// Bit-serial CRC-16 (poly 0x1021, seed 0xFFFF) fed MSB first.
// crc_nx is the value after absorbing din; it is usable in the same cycle.
// Assumes init and en are not needed together (init wins).
module ptx_crc16 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        en,
    input  logic        din,
    output logic [15:0] crc_q,
    output logic [15:0] crc_nx
);
    import ptx_pkg::*;

    assign crc_nx = crc_step(crc_q, din);

    // Accumulator: seeded on init, advanced one bit per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= CRC_SEED;
        end else if (init) begin
            crc_q <= CRC_SEED;
        end else if (en) begin
            crc_q <= crc_nx;
        end
    end

    // R7: every packet's checksum starts from the seed.
    p_seed_after_init_r7: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (crc_q == CRC_SEED));

    // R7: the accumulator is frozen while no covered bit is sent.
    p_hold_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !en) |=> $stable(crc_q));

endmodule

// File: rtl/ptx_field_seq.sv
// Module ptx_field_seq
// Byte-level sequencer: captures configuration when a packet is accepted,
// tracks which field and byte index is on the wire, and supplies the next
// byte at every byte boundary. It pops the queue for inline destination and
// payload bytes. Length inputs outside their legal range are clamped.
// Assumes byte_adv is only raised between accept and the final CRC byte.
module ptx_field_seq #(
    parameter int ADDR_MAX = 5,
    parameter int PAY_MAX  = 32,
    localparam int LEN_W   = $clog2(ADDR_MAX + 1),
    localparam int PLEN_W  = $clog2(PAY_MAX + 1),
    localparam int IDX_W   = (PLEN_W > LEN_W) ? PLEN_W : LEN_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  accept,
    input  logic                  byte_adv,
    input  logic [LEN_W-1:0]      cfg_addr_len,
    input  logic                  cfg_dest_inline,
    input  logic                  cfg_src_en,
    input  logic [PLEN_W-1:0]     cfg_payload_len,
    input  logic [8*ADDR_MAX-1:0] cfg_dest_addr,
    input  logic [8*ADDR_MAX-1:0] cfg_src_addr,
    input  logic [7:0]            q_head,
    input  logic [15:0]           crc_q,
    input  logic [15:0]           crc_nx,
    output logic [7:0]            nxt_byte,
    output logic                  q_pop,
    output logic                  crc_field,
    output logic                  last_byte
);
    import ptx_pkg::*;

    localparam logic [LEN_W-1:0]  L_MAX = LEN_W'(ADDR_MAX);
    localparam logic [PLEN_W-1:0] P_MAX = PLEN_W'(PAY_MAX);

    logic [7:0]        dst_in [ADDR_MAX];
    logic [7:0]        src_in [ADDR_MAX];
    logic [7:0]        dst_q  [ADDR_MAX];
    logic [7:0]        src_q  [ADDR_MAX];
    logic [LEN_W-1:0]  len_c;
    logic [PLEN_W-1:0] pay_c;
    logic [LEN_W-1:0]  len_q;
    logic [PLEN_W-1:0] pay_q;
    logic              inl_q;
    logic              sen_q;
    field_e            field_q;
    logic [IDX_W-1:0]  idx_q;
    field_e            nf;
    logic [IDX_W-1:0]  ni;
    logic [IDX_W-1:0]  len_m1;
    logic [IDX_W-1:0]  pay_m1;
    logic [LEN_W-1:0]  asel;

    // Split the parallel address inputs into bytes, byte k = bits [8k+7:8k].
    for (genvar g = 0; g < ADDR_MAX; g++) begin : g_split
        assign dst_in[g] = cfg_dest_addr[8*g +: 8];
        assign src_in[g] = cfg_src_addr[8*g +: 8];
    end

    // Clamp lengths to their legal ranges.
    always_comb begin
        if (cfg_addr_len == '0)        len_c = LEN_W'(1);
        else if (cfg_addr_len > L_MAX) len_c = L_MAX;
        else                           len_c = cfg_addr_len;
        if (cfg_payload_len == '0)        pay_c = PLEN_W'(1);
        else if (cfg_payload_len > P_MAX) pay_c = P_MAX;
        else                              pay_c = cfg_payload_len;
    end

    // Capture the configuration on accept so later changes have no effect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= LEN_W'(1);
            pay_q <= PLEN_W'(1);
            inl_q <= 1'b0;
            sen_q <= 1'b0;
            for (int k = 0; k < ADDR_MAX; k++) begin
                dst_q[k] <= '0;
                src_q[k] <= '0;
            end
        end else if (accept) begin
            len_q <= len_c;
            pay_q <= pay_c;
            inl_q <= cfg_dest_inline;
            sen_q <= cfg_src_en;
            for (int k = 0; k < ADDR_MAX; k++) begin
                dst_q[k] <= dst_in[k];
                src_q[k] <= src_in[k];
            end
        end
    end

    assign len_m1 = IDX_W'(len_q) - IDX_W'(1);
    assign pay_m1 = IDX_W'(pay_q) - IDX_W'(1);

    // Work out which field and index follows the current byte.
    always_comb begin
        nf = field_q;
        ni = idx_q;
        case (field_q)
            F_PRE: begin
                nf = F_DST;
                ni = '0;
            end
            F_DST: begin
                if (idx_q == len_m1) begin
                    nf = sen_q ? F_SRC : F_PAY;
                    ni = '0;
                end else begin
                    ni = idx_q + IDX_W'(1);
                end
            end
            F_SRC: begin
                if (idx_q == len_m1) begin
                    nf = F_PAY;
                    ni = '0;
                end else begin
                    ni = idx_q + IDX_W'(1);
                end
            end
            F_PAY: begin
                if (idx_q == pay_m1) begin
                    nf = F_CRC;
                    ni = '0;
                end else begin
                    ni = idx_q + IDX_W'(1);
                end
            end
            F_CRC: begin
                ni = idx_q + IDX_W'(1);
            end
            default: begin
                nf = F_PRE;
                ni = '0;
            end
        endcase
    end

    // Address bytes are sent highest index first.
    assign asel = len_q - LEN_W'(1) - LEN_W'(ni);

    // Select the byte to load at the coming boundary.
    always_comb begin
        case (nf)
            F_DST:   nxt_byte = inl_q ? q_head : dst_q[asel];
            F_SRC:   nxt_byte = src_q[asel];
            F_PAY:   nxt_byte = q_head;
            F_CRC:   nxt_byte = (ni == '0) ? crc_nx[15:8] : crc_q[7:0];
            default: nxt_byte = PREAMBLE;
        endcase
    end

    assign q_pop     = byte_adv && ((nf == F_PAY) || ((nf == F_DST) && inl_q));
    assign crc_field = (field_q == F_DST) || (field_q == F_SRC) || (field_q == F_PAY);
    assign last_byte = (field_q == F_CRC) && (idx_q == IDX_W'(1));

    // Field position register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_q <= F_PRE;
            idx_q   <= '0;
        end else if (accept) begin
            field_q <= F_PRE;
            idx_q   <= '0;
        end else if (byte_adv) begin
            field_q <= nf;
            idx_q   <= ni;
        end
    end

    // R5: the sender field is only ever entered when it was enabled.
    p_src_only_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (field_q == F_SRC) |-> sen_q);

    // R1: the preamble byte is always followed by the destination field.
    p_pre_then_dst_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_adv && field_q == F_PRE) |=> (field_q == F_DST));

    // R2: an address index never reaches the captured length.
    p_addr_idx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (field_q == F_DST || field_q == F_SRC) |-> (idx_q < IDX_W'(len_q)));

endmodule

// File: rtl/pkt_tx_assembler.sv
// Module pkt_tx_assembler
// Top of the transmit packet assembler. Owns the bit shifter and the
// idle/send/finish state, and joins the byte queue, field sequencer and
// CRC engine. One bit leaves per clock, MSB first, while tx_valid is high.
// Assumes the host has pushed all inline address and payload bytes into
// the queue before raising start.
module pkt_tx_assembler #(
    parameter int ADDR_MAX = 5,
    parameter int PAY_MAX  = 32,
    localparam int LEN_W   = $clog2(ADDR_MAX + 1),
    localparam int PLEN_W  = $clog2(PAY_MAX + 1),
    localparam int Q_DEPTH = 2 ** $clog2(PAY_MAX + ADDR_MAX)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [LEN_W-1:0]      cfg_addr_len,
    input  logic                  cfg_dest_inline,
    input  logic                  cfg_src_en,
    input  logic [PLEN_W-1:0]     cfg_payload_len,
    input  logic [8*ADDR_MAX-1:0] cfg_dest_addr,
    input  logic [8*ADDR_MAX-1:0] cfg_src_addr,
    input  logic                  q_wr,
    input  logic [7:0]            q_wdata,
    output logic                  tx_bit,
    output logic                  tx_valid,
    output logic                  done,
    output logic                  busy
);
    import ptx_pkg::*;

    tx_state_e   state_q;
    logic [2:0]  bit_cnt;
    logic [7:0]  shreg;
    logic        accept;
    logic        byte_end;
    logic        byte_adv;
    logic        last_byte;
    logic        crc_field;
    logic [7:0]  nxt_byte;
    logic        q_pop;
    logic [7:0]  q_head;
    logic        q_empty;
    logic [15:0] crc_q;
    logic [15:0] crc_nx;

    assign accept   = start && (state_q == S_IDLE);
    assign byte_end = (state_q == S_SEND) && (bit_cnt == 3'd7);
    assign byte_adv = byte_end && !last_byte;

    assign tx_valid = (state_q == S_SEND);
    assign tx_bit   = tx_valid && shreg[7];
    assign done     = (state_q == S_FIN);
    assign busy     = (state_q != S_IDLE);

    ptx_byte_fifo #(.DEPTH(Q_DEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (q_wr),
        .wdata (q_wdata),
        .pop   (q_pop),
        .head  (q_head),
        .empty (q_empty)
    );

    ptx_field_seq #(.ADDR_MAX(ADDR_MAX), .PAY_MAX(PAY_MAX)) u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .accept          (accept),
        .byte_adv        (byte_adv),
        .cfg_addr_len    (cfg_addr_len),
        .cfg_dest_inline (cfg_dest_inline),
        .cfg_src_en      (cfg_src_en),
        .cfg_payload_len (cfg_payload_len),
        .cfg_dest_addr   (cfg_dest_addr),
        .cfg_src_addr    (cfg_src_addr),
        .q_head          (q_head),
        .crc_q           (crc_q),
        .crc_nx          (crc_nx),
        .nxt_byte        (nxt_byte),
        .q_pop           (q_pop),
        .crc_field       (crc_field),
        .last_byte       (last_byte)
    );

    ptx_crc16 u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .init   (accept),
        .en     (tx_valid && crc_field),
        .din    (shreg[7]),
        .crc_q  (crc_q),
        .crc_nx (crc_nx)
    );

    // Transmit state and bit shifter: load a byte, shift it out, move on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (start) begin
                        state_q <= S_SEND;
                        shreg   <= PREAMBLE;
                        bit_cnt <= '0;
                    end
                end
                S_SEND: begin
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) begin
                        if (last_byte) state_q <= S_FIN;
                        else           shreg   <= nxt_byte;
                    end else begin
                        shreg <= {shreg[6:0], 1'b0};
                    end
                end
                S_FIN: begin
                    state_q <= S_IDLE;
                end
                default: begin
                    state_q <= S_IDLE;
                end
            endcase
        end
    end

    // R1: every packet opens with a one bit.
    p_first_bit_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> tx_bit);

    // R8: the stream only stops into the completion cycle.
    p_stop_into_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_valid) |-> done);

    // R8: completion is a single-cycle pulse.
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: a start seen mid-packet does not restart or stall the stream.
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && start) |=> (tx_valid || done));

    // R10: after reset nothing is in flight.
    p_reset_idle_r10: assert property (@(posedge clk)
        !rst_n |=> (!busy && !tx_valid && !done));

endmodule

// File: tb/tb_pkt_tx_assembler.sv
// Bench for pkt_tx_assembler: a table of packet layouts walked by one loop,
// then directed runs for reset flushing and mid-packet disturbance.
module tb_pkt_tx_assembler;

    typedef struct packed {
        logic [2:0]  alen;
        logic        inl;
        logic        srce;
        logic [5:0]  plen;
        logic [39:0] dst;
        logic [39:0] src;
        logic [39:0] ibytes;
        logic [7:0]  seed;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VT [NV] = '{
        '{3'd1, 1'b0, 1'b0, 6'd1,  40'h00000000A5, 40'h0,          40'h0,          8'h10},
        '{3'd5, 1'b0, 1'b1, 6'd32, 40'h0123456789, 40'hFEDCBA9876, 40'h0,          8'h01},
        '{3'd3, 1'b1, 1'b0, 6'd4,  40'hFFFFC1D2E3, 40'h0,          40'h00005A3C99, 8'h44},
        '{3'd2, 1'b1, 1'b1, 6'd7,  40'h000000BEEF, 40'h0000007E81, 40'h000000C3D4, 8'h80},
        '{3'd0, 1'b0, 1'b1, 6'd0,  40'h1111111177, 40'h22222222E8, 40'h0,          8'hF0},
        '{3'd7, 1'b0, 1'b0, 6'd40, 40'hA1B2C3D4E5, 40'h0,          40'h0,          8'h3B}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  cfg_addr_len = '0;
    logic        cfg_dest_inline = 1'b0;
    logic        cfg_src_en = 1'b0;
    logic [5:0]  cfg_payload_len = '0;
    logic [39:0] cfg_dest_addr = '0;
    logic [39:0] cfg_src_addr = '0;
    logic        q_wr = 1'b0;
    logic [7:0]  q_wdata = '0;
    logic        tx_bit;
    logic        tx_valid;
    logic        done;
    logic        busy;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic exp_b [0:511];
    logic got_b [0:511];
    int   n_exp;
    int   n_got;
    int   seg_dst, seg_src, seg_pay, seg_crc;
    bit   last_ok;

    always #10 clk = ~clk;

    pkt_tx_assembler dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .start           (start),
        .cfg_addr_len    (cfg_addr_len),
        .cfg_dest_inline (cfg_dest_inline),
        .cfg_src_en      (cfg_src_en),
        .cfg_payload_len (cfg_payload_len),
        .cfg_dest_addr   (cfg_dest_addr),
        .cfg_src_addr    (cfg_src_addr),
        .q_wr            (q_wr),
        .q_wdata         (q_wdata),
        .tx_bit          (tx_bit),
        .tx_valid        (tx_valid),
        .done            (done),
        .busy            (busy)
    );

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[15] ^ b;
        return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    endfunction

    function automatic logic [7:0] pay_byte(input logic [7:0] seed, input int i);
        return seed + 8'(i * 37);
    endfunction

    task automatic push_exp(input logic [7:0] b);
        for (int k = 7; k >= 0; k--) begin
            exp_b[n_exp] = b[k];
            n_exp++;
        end
    endtask

    task automatic q_push(input logic [7:0] b);
        @(negedge clk);
        q_wr = 1'b1;
        q_wdata = b;
        @(negedge clk);
        q_wr = 1'b0;
    endtask

    // Count mismatching bits between got and exp over [lo, lo+len).
    function automatic int seg_err(input int lo, input int len);
        int e = 0;
        for (int i = lo; i < lo + len; i++) begin
            if (got_b[i] !== exp_b[i]) e++;
        end
        return e;
    endfunction

    task automatic run_pkt(input vec_t v, input bit disturb);
        int L, P, e;
        int first_c, last_c, done_c, ndone;
        bit gap, seen;
        logic [15:0] c;
        L = (v.alen == 0) ? 1 : (v.alen > 5) ? 5 : int'(v.alen);
        P = (v.plen == 0) ? 1 : (v.plen > 32) ? 32 : int'(v.plen);
        // expected stream
        n_exp = 0;
        push_exp(8'hAA);
        seg_dst = n_exp;
        for (int k = L - 1; k >= 0; k--)
            push_exp(v.inl ? v.ibytes[8*k +: 8] : v.dst[8*k +: 8]);
        seg_src = n_exp;
        if (v.srce)
            for (int k = L - 1; k >= 0; k--) push_exp(v.src[8*k +: 8]);
        seg_pay = n_exp;
        for (int i = 0; i < P; i++) push_exp(pay_byte(v.seed, i));
        seg_crc = n_exp;
        c = 16'hFFFF;
        for (int i = 8; i < seg_crc; i++) c = crc_upd(c, exp_b[i]);
        push_exp(c[15:8]);
        push_exp(c[7:0]);
        // load the queue
        if (v.inl)
            for (int k = L - 1; k >= 0; k--) q_push(v.ibytes[8*k +: 8]);
        for (int i = 0; i < P; i++) q_push(pay_byte(v.seed, i));
        @(negedge clk);
        cfg_addr_len = v.alen;
        cfg_dest_inline = v.inl;
        cfg_src_en = v.srce;
        cfg_payload_len = v.plen;
        cfg_dest_addr = v.dst;
        cfg_src_addr = v.src;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n_got = 0; first_c = -1; last_c = -1; done_c = -1; ndone = 0;
        gap = 1'b0; seen = 1'b0;
        for (int cy = 0; cy < 1000; cy++) begin
            if (tx_valid) begin
                if (first_c < 0) first_c = cy;
                if (seen && last_c != cy - 1) gap = 1'b1;
                seen = 1'b1;
                last_c = cy;
                if (n_got < 512) got_b[n_got] = tx_bit;
                n_got++;
            end
            if (done) begin
                ndone++;
                if (done_c < 0) done_c = cy;
            end
            if (disturb && cy == 12) begin
                start = 1'b1;
                cfg_addr_len = 3'd4;
                cfg_dest_inline = ~v.inl;
                cfg_src_en = ~v.srce;
                cfg_payload_len = 6'd9;
                cfg_dest_addr = ~v.dst;
                cfg_src_addr = ~v.src;
            end
            if (disturb && cy == 13) start = 1'b0;
            if (done_c >= 0 && cy >= done_c + 3) break;
            @(negedge clk);
        end
        start = 1'b0;
        // checks
        chk(first_c == 0 && !gap, "R1 stream starts one cycle after accept, no gap", first_c, 0);
        chk(n_got >= 8 && seg_err(0, 8) == 0, "R1 preamble 10101010", n_got, 8);
        chk(n_got == n_exp, "R2 R5 R6 total packet length", n_got, n_exp);
        if (n_got == n_exp) begin
            e = seg_err(seg_dst, seg_src - seg_dst);
            if (v.inl) chk(e == 0, "R4 inline destination bytes", e, 0);
            else       chk(e == 0, "R3 stored destination bytes", e, 0);
            e = seg_err(seg_src, seg_pay - seg_src);
            chk(e == 0, "R5 sender field", e, 0);
            e = seg_err(seg_pay, seg_crc - seg_pay);
            chk(e == 0, "R6 payload bytes", e, 0);
            e = seg_err(seg_crc, 16);
            chk(e == 0, "R7 CRC bits", e, 0);
        end
        chk(ndone == 1 && done_c == last_c + 1, "R8 done one cycle after last bit", done_c, last_c + 1);
        last_ok = (n_got == n_exp) && (seg_err(0, n_exp) == 0);
        if (disturb) begin
            chk(last_ok, "R9 mid-packet start and config change ignored", n_got, n_exp);
            chk(!busy && !tx_valid, "R9 idle after done", {busy, tx_valid}, 0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R10: reset state at the ports
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!tx_valid && !done && !busy, "R10 outputs idle after reset", {tx_valid, done, busy}, 0);
        // stale bytes, then reset must flush them
        q_push(8'hDE);
        q_push(8'hAD);
        q_push(8'hBE);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!tx_valid && !done && !busy, "R10 outputs idle during reset", {tx_valid, done, busy}, 0);
        rst_n = 1'b1;
        run_pkt(VT[0], 1'b0);
        chk(last_ok, "R10 queue emptied by reset", last_ok, 1);

        // table of layouts
        for (int i = 0; i < NV; i++) begin
            run_pkt(VT[i], 1'b0);
        end

        // R9: start pulse and configuration change while sending
        run_pkt(VT[3], 1'b1);
        run_pkt(VT[1], 1'b1);

        // R2 R6: back-to-back clamp case after a disturbed run
        run_pkt(VT[4], 1'b0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule